// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block runs the external bus cycle for a processor whose address and low data bits share one set of lines. A request carries a 20-bit address, 16 bits of write data, a byte-high enable, a memory-or-I/O select and a read/write flag. Each accepted request moves through four timed states: T1, T2, T3 and T4. Wait states go between T2 and T3 for as long as the target holds its ready input low. Every control output comes from a register, so in any clock period its value matches the bus state of that period.

In T1 the block puts the address on the shared lines and pulses the address latch enable. The read or write strobe and the data enable are active through T2, any wait states and T3. In T4 everything returns to rest. A model of the external transparent latch gives a stable demultiplexed address and byte-high enable for the rest of the cycle. Read data is taken from the shared lines at the end of T3. A one-cycle done pulse follows T4. A new request may be taken in T4, so cycles can run back to back with no idle period between them.

Top module: `mux_bus_sequencer`

## Requirements
- R1: `req_ready` is high only in the idle state and in T4. A request is taken when `req_valid` and `req_ready` are both high at a clock edge, and T1 starts in the next period. A `req_valid` in any other state is ignored: it has no effect on the bus outputs or on the latched address.
- R2: T1 lasts exactly one period. In T1, `ale`=1 and `ad_oe`=1. `ad_out` carries address bits 15..0 and `a_hi` carries address bits 19..16. `m_io` equals the request's memory flag (1 = memory). `dt_r` equals the write flag (1 = transmit/write, 0 = receive/read). `bhe_n` is the inverse of the request's byte-high enable. Outside T1, `ale`=0 and `a_hi`=0.
- R3: The active-low strobes are asserted in T2, in every wait state and in T3. For a read, `rd_n`=0. For a write, `wr_n`=0. In both cases `den_n`=0. `rd_n` and `wr_n` are never low together.
- R4: For a write, `ad_oe`=1 and `ad_out` carries the write data from T2 through T3. For a read, `ad_oe`=0 from T2 through T4.
- R5: `ready` is sampled at the end of T2 and at the end of each wait state. Each low sample adds one wait state. A high sample moves the cycle to T3.
- R6: For a read, `rdata` takes the value of `ad_in` at the end of T3 only. Values on `ad_in` in T2 and in wait states are not used.
- R7: In T4 and when idle, `rd_n`, `wr_n` and `den_n` are 1, and `ad_oe`, `dt_r` and `m_io` are 0.
- R8: `latched_addr` and `latched_bhe_n` follow the bus while `ale` is high. They hold that value after `ale` falls, until the next T1.
- R9: `done` is high for exactly the one period after T4, with the read data on `rdata`. With `req_valid` held high, the next T1 comes directly after T4.
- R10: Reset is synchronous and active high. After reset the block is idle, with `ale`=0, `done`=0, all strobes high, `ad_oe`=0 and `req_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this period |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mem | input | 1 | 1 = memory, 0 = I/O |
| req_bhe | input | 1 | High byte enabled (active high) |
| req_addr | input | 20 | Bus address |
| req_wdata | input | 16 | Write data |
| ad_out | output | 16 | Shared address/data lines, outgoing value |
| ad_oe | output | 1 | Shared lines driven by this block |
| ad_in | input | 16 | Shared address/data lines, incoming value |
| a_hi | output | 4 | Upper address bits |
| bhe_n | output | 1 | Byte-high enable, active low |
| ale | output | 1 | Address latch enable |
| dt_r | output | 1 | Direction: 1 transmit, 0 receive |
| den_n | output | 1 | Data buffer enable, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| m_io | output | 1 | 1 = memory, 0 = I/O |
| ready | input | 1 | Target ready; low adds wait states |
| latched_addr | output | 20 | Demultiplexed address from latch model |
| latched_bhe_n | output | 1 | Latched byte-high enable |
| done | output | 1 | One-period completion pulse |
| rdata | output | 16 | Read data |

## Verification
The bench uses the default widths of 20 address bits and 16 data bits, so it checks exactly the bus split that the requirements describe. Wait-state counts from zero to three are swept across every combination of read/write, memory/I/O and byte-high enable. This reaches every state path, including a direct move from T2 to T3 and repeated wait states. Each transaction has its own address and data pattern, computed arithmetically. A decoy value on the input lines outside T3 and a decoy request during the busy phase expose mistimed capture and wrongly accepted requests.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_TW   = 3'd3,
    ST_T3   = 3'd4,
    ST_T4   = 3'd5
  } bus_st_e;
endpackage

// File: rtl/bus_seq_fsm.sv
module bus_seq_fsm
  import bus_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    req_valid,
  input  logic    ready,
  output logic    accept,
  output logic    can_take,
  output bus_st_e state_q,
  output bus_st_e state_d
);
  assign can_take = (state_q == ST_IDLE) || (state_q == ST_T4);
  assign accept   = can_take && req_valid;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: state_d = accept ? ST_T1 : ST_IDLE;
      ST_T1:   state_d = ST_T2;
      ST_T2:   state_d = ready ? ST_T3 : ST_TW;
      ST_TW:   state_d = ready ? ST_T3 : ST_TW;
      ST_T3:   state_d = ST_T4;
      ST_T4:   state_d = accept ? ST_T1 : ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  // R5: a low ready at the end of T2 leads into a wait state
  a_r5_wait_on_low: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_T2 && !ready) |=> state_q == ST_TW);
  // R5: wait states end only on a high ready sample
  a_r5_wait_exit: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_TW && ready) |=> state_q == ST_T3);
  // R1: no request means the sequencer rests after T4 or idle
  a_r1_rest: assert property (@(posedge clk) disable iff (rst)
    (can_take && !req_valid) |=> state_q == ST_IDLE);
endmodule

// File: rtl/bus_seq_pins.sv
module bus_seq_pins
  import bus_seq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  bus_st_e                  state_q,
  input  bus_st_e                  state_d,
  input  logic                     accept,
  input  logic                     req_write,
  input  logic                     req_mem,
  input  logic                     req_bhe,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  input  logic [DATA_W-1:0]        ad_in,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  output logic [ADDR_W-DATA_W-1:0] a_hi,
  output logic                     bhe_n,
  output logic                     ale,
  output logic                     dt_r,
  output logic                     den_n,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic                     m_io,
  output logic                     done,
  output logic [DATA_W-1:0]        rdata
);
  localparam int HI_W = ADDR_W - DATA_W;

  logic              wr_q, mem_q, bhe_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              f_wr, f_mem, f_bhe;
  logic [ADDR_W-1:0] f_addr;
  logic [DATA_W-1:0] f_wdata;
  logic              strobe_d, active_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q <= 1'b0; mem_q <= 1'b0; bhe_q <= 1'b0;
      addr_q <= '0; wdata_q <= '0;
    end else if (accept) begin
      wr_q <= req_write; mem_q <= req_mem; bhe_q <= req_bhe;
      addr_q <= req_addr; wdata_q <= req_wdata;
    end
  end

  assign f_wr    = accept ? req_write : wr_q;
  assign f_mem   = accept ? req_mem   : mem_q;
  assign f_bhe   = accept ? req_bhe   : bhe_q;
  assign f_addr  = accept ? req_addr  : addr_q;
  assign f_wdata = accept ? req_wdata : wdata_q;

  assign strobe_d = (state_d == ST_T2) || (state_d == ST_TW) || (state_d == ST_T3);
  assign active_d = (state_d == ST_T1) || strobe_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      ale <= 1'b0; ad_oe <= 1'b0; ad_out <= '0; a_hi <= '0;
      bhe_n <= 1'b1; dt_r <= 1'b0; m_io <= 1'b0;
      den_n <= 1'b1; rd_n <= 1'b1; wr_n <= 1'b1;
    end else begin
      ale    <= (state_d == ST_T1);
      a_hi   <= (state_d == ST_T1) ? f_addr[ADDR_W-1:DATA_W] : {HI_W{1'b0}};
      bhe_n  <= active_d ? ~f_bhe : 1'b1;
      dt_r   <= active_d && f_wr;
      m_io   <= active_d && f_mem;
      den_n  <= ~strobe_d;
      rd_n   <= ~(strobe_d && !f_wr);
      wr_n   <= ~(strobe_d && f_wr);
      ad_oe  <= (state_d == ST_T1) || (strobe_d && f_wr);
      if (state_d == ST_T1)        ad_out <= f_addr[DATA_W-1:0];
      else if (strobe_d && f_wr)   ad_out <= f_wdata;
      else                         ad_out <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done  <= 1'b0;
      rdata <= '0;
    end else begin
      done <= (state_q == ST_T4);
      if (state_q == ST_T3 && !wr_q) rdata <= ad_in;
    end
  end

  // R3: read and write strobes never overlap
  a_r3_strobe_excl: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n));
  // R2: address enable lasts a single period
  a_r2_ale_single: assert property (@(posedge clk) disable iff (rst)
    ale |=> !ale);
  // R4: lines float while a read strobe is active
  a_r4_read_float: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> !ad_oe);
  // R9: completion pulse follows T4
  a_r9_done_after_t4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_T4) |=> done);
  // R7: T4 leaves all strobes released
  a_r7_t4_quiet: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_T4) |-> (rd_n && wr_n && den_n && !ad_oe));
endmodule

// File: rtl/addr_latch_model.sv
module addr_latch_model #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ale,
  input  logic [DATA_W-1:0]        ad_out,
  input  logic [ADDR_W-DATA_W-1:0] a_hi,
  input  logic                     bhe_n,
  output logic [ADDR_W-1:0]        latched_addr,
  output logic                     latched_bhe_n
);
  logic [ADDR_W-1:0] hold_addr;
  logic              hold_bhe_n;
  logic [ADDR_W-1:0] live_addr;

  assign live_addr = {a_hi, ad_out};

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_addr  <= '0;
      hold_bhe_n <= 1'b1;
    end else if (ale) begin
      hold_addr  <= live_addr;
      hold_bhe_n <= bhe_n;
    end
  end

  assign latched_addr  = ale ? live_addr : hold_addr;
  assign latched_bhe_n = ale ? bhe_n     : hold_bhe_n;

  // R8: with the enable low the held address does not move
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (!ale && !$past(ale)) |-> $stable(hold_addr));
  // R8: the held value matches what the bus showed when the enable fell
  a_r8_capture: assert property (@(posedge clk) disable iff (rst)
    $fell(ale) |-> hold_addr == $past(live_addr));
endmodule

// File: rtl/mux_bus_sequencer.sv
module mux_bus_sequencer
  import bus_seq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic                     req_mem,
  input  logic                     req_bhe,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  input  logic [DATA_W-1:0]        ad_in,
  output logic [ADDR_W-DATA_W-1:0] a_hi,
  output logic                     bhe_n,
  output logic                     ale,
  output logic                     dt_r,
  output logic                     den_n,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic                     m_io,
  input  logic                     ready,
  output logic [ADDR_W-1:0]        latched_addr,
  output logic                     latched_bhe_n,
  output logic                     done,
  output logic [DATA_W-1:0]        rdata
);
  bus_st_e state_q, state_d;
  logic    accept;

  bus_seq_fsm u_fsm (
    .clk(clk), .rst(rst), .req_valid(req_valid), .ready(ready),
    .accept(accept), .can_take(req_ready),
    .state_q(state_q), .state_d(state_d)
  );

  bus_seq_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk(clk), .rst(rst), .state_q(state_q), .state_d(state_d),
    .accept(accept), .req_write(req_write), .req_mem(req_mem),
    .req_bhe(req_bhe), .req_addr(req_addr), .req_wdata(req_wdata),
    .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .a_hi(a_hi),
    .bhe_n(bhe_n), .ale(ale), .dt_r(dt_r), .den_n(den_n),
    .rd_n(rd_n), .wr_n(wr_n), .m_io(m_io), .done(done), .rdata(rdata)
  );

  addr_latch_model #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_latch (
    .clk(clk), .rst(rst), .ale(ale), .ad_out(ad_out), .a_hi(a_hi),
    .bhe_n(bhe_n), .latched_addr(latched_addr), .latched_bhe_n(latched_bhe_n)
  );

  // R1: a cycle starts only from a state that may take a request
  a_r1_start: assert property (@(posedge clk) disable iff (rst)
    $rose(ale) |-> $past(req_ready && req_valid));
endmodule

// File: tb/test_mux_bus_sequencer.sv
module test_mux_bus_sequencer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0, req_mem = 1'b0, req_bhe = 1'b0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0, ad_in = '0;
  logic ready = 1'b1;
  logic req_ready, ad_oe, bhe_n, ale, dt_r, den_n, rd_n, wr_n, m_io, latched_bhe_n, done;
  logic [15:0] ad_out, rdata;
  logic [3:0]  a_hi;
  logic [19:0] latched_addr;
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  mux_bus_sequencer i_mux_bus_sequencer (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_mem(req_mem), .req_bhe(req_bhe),
    .req_addr(req_addr), .req_wdata(req_wdata), .ad_out(ad_out), .ad_oe(ad_oe),
    .ad_in(ad_in), .a_hi(a_hi), .bhe_n(bhe_n), .ale(ale), .dt_r(dt_r),
    .den_n(den_n), .rd_n(rd_n), .wr_n(wr_n), .m_io(m_io), .ready(ready),
    .latched_addr(latched_addr), .latched_bhe_n(latched_bhe_n),
    .done(done), .rdata(rdata)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0h expected %0h", rq, $time, act, exp);
    end
  endtask

  // One transaction with w wait states; c counts periods from T1
  task automatic run_txn(input int w, input bit wr, input bit mem, input bit bhe,
                         input logic [19:0] addr, input logic [15:0] wd,
                         input logic [15:0] rv);
    int last;
    bit strobe;
    last = 4 + w;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_mem = mem; req_bhe = bhe;
    req_addr = addr; req_wdata = wd;
    chk("R1 ready idle", req_ready, 1);
    @(posedge clk);
    for (int c = 0; c <= last; c++) begin
      @(negedge clk);
      // decoy request while busy; dropped before T4 ends
      if (c >= 1 && c < 3 + w) begin
        req_valid = 1; req_addr = ~addr; req_write = ~wr;
      end else req_valid = 0;
      ready = (c >= 1) ? (c - 1 >= w) : 1'b0;
      ad_in = (c == 2 + w) ? rv : ~rv;
      strobe = (c >= 1) && (c <= 2 + w);
      chk("R2 ale", ale, (c == 0));
      chk("R2 a_hi", a_hi, (c == 0) ? addr[19:16] : 4'h0);
      chk("R3 rd_n", rd_n, !(strobe && !wr));
      chk("R3 wr_n", wr_n, !(strobe && wr));
      chk("R3 den_n", den_n, !strobe);
      chk("R2 R7 dt_r", dt_r, (c <= 2 + w) ? wr : 1'b0);
      chk("R2 R7 m_io", m_io, (c <= 2 + w) ? mem : 1'b0);
      chk("R4 ad_oe", ad_oe, (c == 0) || (strobe && wr));
      if (c == 0) chk("R2 ad_out addr", ad_out, addr[15:0]);
      else if (strobe && wr) chk("R4 ad_out wdata", ad_out, wd);
      if (c <= 2 + w) chk("R2 bhe_n", bhe_n, !bhe);
      chk("R8 latched_addr", latched_addr, addr);
      chk("R8 latched_bhe_n", latched_bhe_n, !bhe);
      chk("R1 req_ready", req_ready, (c == 3 + w) || (c == last));
      chk("R9 done", done, (c == last));
      if (c == last && !wr) chk("R6 rdata", rdata, rv);
    end
    ready = 1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R10 reset state
    chk("R10 ale", ale, 0); chk("R10 done", done, 0);
    chk("R10 rd_n", rd_n, 1); chk("R10 wr_n", wr_n, 1);
    chk("R10 den_n", den_n, 1); chk("R10 ad_oe", ad_oe, 0);
    chk("R10 req_ready", req_ready, 1);
    // R5 sweep of wait counts with all request flag combinations
    for (int i = 0; i < 64; i++) begin
      logic [19:0] a;
      logic [15:0] d;
      a = 20'hF0000 ^ (20'(i) * 20'h1357B);
      d = (16'(i) * 16'h03A5) ^ 16'h5A5A;
      run_txn(i % 4, i[2], i[3], i[4], a, d, d + 16'(i) + 16'h1111);
    end
    // R9 back-to-back: request held through T4
    @(negedge clk);
    req_valid = 1; req_write = 1; req_mem = 1; req_bhe = 1;
    req_addr = 20'hABCDE; req_wdata = 16'h1234; ready = 1;
    @(posedge clk);
    repeat (4) @(negedge clk);
    req_addr = 20'h12345;
    @(negedge clk);
    chk("R9 back-to-back done", done, 1);
    chk("R9 back-to-back ale", ale, 1);
    chk("R9 back-to-back addr", latched_addr, 20'h12345);
    req_valid = 0;
    repeat (6) @(negedge clk);
    chk("R1 idle after", ale, 0);
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule